// File: doc/BRIEF.md
# SD Card SPI-Mode Block Sequencer

This block runs an SD or MMC card in SPI mode on its own. The user asks for one of three operations: bring the card up, read sectors, or write sectors. A read or write carries a byte address and a block count. The sequencer produces every byte the card protocol needs: command frames, busy polling, bounded response polling, data tokens, dummy CRC bytes, the stuff byte after a stop command and the write data-response check. Each operation ends with one completion pulse and an error code.

On the card side the block does not shift bits itself. It hands one byte at a time to a separate serial shifter through a start pulse. The shifter returns the byte it clocked in together with a completion pulse. Exactly one exchange is in flight at a time. The block drives the chip select directly, and it also drives a clock-rate select that tells the shifter when to move from the slow bring-up rate to the fast data rate.

Sector data leaves on a read stream and enters on a write stream, each with a valid/ready handshake. Backpressure on the read stream stalls the card exchange, so no byte is ever lost.

Top module: `sd_spi_seq`

## Requirements
- R1: A command goes out as six bytes: first `0x40 | index` (upper two bits `01`), then the 32-bit argument starting with the most significant byte, and last the fixed CRC byte `0x95`.
- R2: Before every command, every write data packet and the multi-block stop token, the block sends `0xFF` bytes and keeps doing so until it receives `0xFF`.
- R3: After a command the block sends at most 10 polling bytes of `0xFF` and accepts the first received byte whose bit 7 is clear. If no such byte arrives, the operation ends with error code 1 (timeout).
- R4: After a stop command (index 12) one received byte is thrown away before response polling starts, even if that byte looks like a valid response.
- R5: For a read, `0xFF` bytes are skipped until the token `0xFE` arrives. The next 512 bytes appear in order on the read stream, and the 2 bytes after them are dropped. Any token other than `0xFF` or `0xFE` ends the block with error code 3.
- R6: A write packet is the token `0xFE` for a single-block write or `0xFC` for a multi-block write, then 512 bytes taken from the write stream in order, then two `0xFF` bytes.
- R7: A write block counts as accepted only when bits 4..0 of the byte received after its CRC equal `0x05`. Otherwise the operation ends with error code 4. A multi-block write ends with a ready poll and then the token `0xFD`.
- R8: Bring-up (op 0) sends 10 `0xFF` bytes with chip select high. It then sends command 0 and requires response `0x01`; any other response gives error code 2. It then repeats command 1 until the response is `0x00`.
- R9: A read (op 1) uses command 17 when the count is 1 and command 18 when the count is more than 1. A write (op 2) uses command 24 or command 25 in the same way. The argument is the request address. A non-zero command response ends the operation with error code 2.
- R10: Every operation ends with chip select high while one `0xFF` byte is exchanged. `done_o` then pulses for exactly one cycle with the error code and `req_ready_o` returns.
- R11: `fast_clk_o` goes low when bring-up starts and goes high only when command 1 returns `0x00`. A failed bring-up leaves it low.
- R12: An error aborts the operation. A multi-block read that fails on a data token still sends command 12 before it releases the card. `err_blk_o` gives the zero-based index of the block that failed.
- R13: `rd_valid_o` and `rd_data_o` stay unchanged until `rd_ready_i` is seen. No further card byte is exchanged while a read byte is still held.
- R14: After reset, chip select is high, `req_ready_o` is high, and `fast_clk_o`, `done_o` and `xfer_start_o` are low. A new exchange starts only after the previous completion has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Operation request |
| req_ready_o | output | 1 | Sequencer idle, request taken |
| req_op_i | input | 2 | 0 bring-up, 1 read, 2 write |
| req_addr_i | input | 32 | Card byte address (command argument) |
| req_count_i | input | CNT_W | Number of 512-byte blocks (0 treated as 1) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | High with done_o when the operation failed |
| err_code_o | output | 3 | 0 ok, 1 timeout, 2 bad response, 3 bad token, 4 write rejected |
| err_blk_o | output | CNT_W | Index of the failing block |
| fast_clk_o | output | 1 | Selects the fast serial clock rate |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | Read byte accepted |
| rd_data_o | output | 8 | Read byte |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Write byte taken |
| wr_data_i | input | 8 | Write byte |
| xfer_start_o | output | 1 | Start one byte exchange |
| xfer_tx_o | output | 8 | Byte to send |
| xfer_done_i | input | 1 | Exchange complete |
| xfer_rx_i | input | 8 | Byte received |
| cs_no | output | 1 | Card chip select, active low |

## Verification
The assertions make two assumptions about the inputs. First, the shifter raises `xfer_done_i` only while an exchange is outstanding, and only once for each start. Second, the read-stream hold check assumes the consumer drops nothing while `rd_ready_i` is low. The bench's card model keeps within both assumptions: it answers every start with a single completion two half-cycles later and never responds on its own. The consumer toggles `rd_ready_i` in a fixed pattern so that the hold path is exercised. Every card reply is scripted byte by byte, so each command's response, busy and token sequence is fixed in advance.

// File: rtl/sd_seq_pkg.sv
package sd_seq_pkg;
  typedef enum logic [4:0] {
    ST_IDLE, ST_DUMMY, ST_CRDY, ST_CMD, ST_STUFF, ST_RESP,
    ST_TOK, ST_RDATA, ST_RCRC,
    ST_WRDY, ST_WTOK, ST_WDATA, ST_WCRC, ST_WRESP,
    ST_SRDY, ST_STOP, ST_FIN, ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_TIMEOUT = 3'd1,
    ERR_RESP    = 3'd2,
    ERR_TOKEN   = 3'd3,
    ERR_REJECT  = 3'd4
  } seq_err_e;

  localparam logic [1:0] OP_INIT  = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;

  localparam logic [5:0] CMD_RESET = 6'd0;
  localparam logic [5:0] CMD_INIT  = 6'd1;
  localparam logic [5:0] CMD_STOP  = 6'd12;
  localparam logic [5:0] CMD_RD1   = 6'd17;
  localparam logic [5:0] CMD_RDN   = 6'd18;
  localparam logic [5:0] CMD_WR1   = 6'd24;
  localparam logic [5:0] CMD_WRN   = 6'd25;

  localparam logic [7:0] BYTE_IDLE  = 8'hFF;
  localparam logic [7:0] TOK_SINGLE = 8'hFE;
  localparam logic [7:0] TOK_MULTI  = 8'hFC;
  localparam logic [7:0] TOK_STOP   = 8'hFD;
endpackage

// File: rtl/sd_cmd_frame.sv
module sd_cmd_frame #(
  parameter logic [7:0] CRC_BYTE = 8'h95
) (
  input  logic [5:0]  idx_i,
  input  logic [31:0] arg_i,
  input  logic [2:0]  sel_i,
  output logic [7:0]  byte_o
);
  always_comb begin
    case (sel_i)
      3'd0:    byte_o = {2'b01, idx_i};
      3'd1:    byte_o = arg_i[31:24];
      3'd2:    byte_o = arg_i[23:16];
      3'd3:    byte_o = arg_i[15:8];
      3'd4:    byte_o = arg_i[7:0];
      default: byte_o = CRC_BYTE;
    endcase
  end
endmodule

// File: rtl/sd_xfer_port.sv
module sd_xfer_port (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       issue_i,
  input  logic [7:0] tx_i,
  output logic       start_o,
  output logic [7:0] tx_o,
  input  logic       xfer_done_i,
  input  logic [7:0] xfer_rx_i,
  output logic       pend_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  logic pend_q;

  assign start_o = issue_i & ~pend_q;
  assign tx_o    = tx_i;
  assign done_o  = xfer_done_i & pend_q;
  assign rx_o    = xfer_rx_i;
  assign pend_o  = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (start_o)     pend_q <= 1'b1;
    else if (xfer_done_i) pend_q <= 1'b0;
  end

  AST_DONE_ONLY_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |-> pend_q); // R14
endmodule

// File: rtl/sd_spi_seq.sv
module sd_spi_seq
  import sd_seq_pkg::*;
#(
  parameter int BLK_BYTES = 512,
  parameter int CNT_W     = 8,
  parameter int POLL_N    = 10,
  parameter int DUMMY_N   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [31:0]      req_addr_i,
  input  logic [CNT_W-1:0] req_count_i,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o,
  output logic [CNT_W-1:0] err_blk_o,
  output logic             fast_clk_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [7:0]       rd_data_o,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [7:0]       wr_data_i,
  output logic             xfer_start_o,
  output logic [7:0]       xfer_tx_o,
  input  logic             xfer_done_i,
  input  logic [7:0]       xfer_rx_i,
  output logic             cs_no
);
  localparam int BW = $clog2(BLK_BYTES);
  localparam int PW = $clog2(POLL_N);

  seq_state_e       state_q;
  seq_err_e         err_q;
  logic [BW-1:0]    cnt_q;
  logic [PW-1:0]    poll_q;
  logic [CNT_W-1:0] blk_q, nblk_q, err_blk_q;
  logic             multi_q, fast_q, rd_valid_q;
  logic [7:0]       rd_data_q;
  logic [5:0]       cmd_q;
  logic [31:0]      arg_q;

  logic       issue, pend, x_done;
  logic [7:0] tx, rx, frame_byte;
  logic       last_blk, req_multi;

  assign last_blk  = (blk_q == nblk_q - CNT_W'(1));
  assign req_multi = (req_count_i > CNT_W'(1));

  sd_cmd_frame #(.CRC_BYTE(8'h95)) i_frame (
    .idx_i(cmd_q), .arg_i(arg_q), .sel_i(cnt_q[2:0]), .byte_o(frame_byte)
  );

  sd_xfer_port i_port (
    .clk_i, .rst_ni,
    .issue_i(issue), .tx_i(tx),
    .start_o(xfer_start_o), .tx_o(xfer_tx_o),
    .xfer_done_i, .xfer_rx_i,
    .pend_o(pend), .done_o(x_done), .rx_o(rx)
  );

  always_comb begin
    issue = 1'b0;
    tx    = BYTE_IDLE;
    case (state_q)
      ST_DUMMY, ST_CRDY, ST_STUFF, ST_RESP, ST_TOK, ST_RCRC,
      ST_WRDY, ST_WCRC, ST_WRESP, ST_SRDY, ST_FIN: issue = 1'b1;
      ST_CMD:   begin issue = 1'b1; tx = frame_byte; end
      ST_RDATA: issue = ~rd_valid_q;
      ST_WTOK:  begin issue = 1'b1; tx = multi_q ? TOK_MULTI : TOK_SINGLE; end
      ST_WDATA: begin issue = wr_valid_i; tx = wr_data_i; end
      ST_STOP:  begin issue = 1'b1; tx = TOK_STOP; end
      default:  ;
    endcase
  end

  assign wr_ready_o  = (state_q == ST_WDATA) & ~pend;
  assign req_ready_o = (state_q == ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = done_o & (err_q != ERR_NONE);
  assign err_code_o  = err_q;
  assign err_blk_o   = err_blk_q;
  assign fast_clk_o  = fast_q;
  assign rd_valid_o  = rd_valid_q;
  assign rd_data_o   = rd_data_q;
  assign cs_no       = (state_q == ST_IDLE) | (state_q == ST_DUMMY) |
                       (state_q == ST_FIN)  | (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      err_q      <= ERR_NONE;
      cnt_q      <= '0;
      poll_q     <= '0;
      blk_q      <= '0;
      nblk_q     <= '0;
      err_blk_q  <= '0;
      multi_q    <= 1'b0;
      fast_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      cmd_q      <= '0;
      arg_q      <= '0;
    end else begin
      if (rd_valid_q && rd_ready_i) rd_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          err_q     <= ERR_NONE;
          err_blk_q <= '0;
          blk_q     <= '0;
          cnt_q     <= '0;
          poll_q    <= '0;
          arg_q     <= req_addr_i;
          multi_q   <= req_multi;
          nblk_q    <= (req_count_i == '0) ? CNT_W'(1) : req_count_i;
          case (req_op_i)
            OP_INIT: begin
              fast_q <= 1'b0; cmd_q <= CMD_RESET; arg_q <= '0; state_q <= ST_DUMMY;
            end
            OP_READ:  begin cmd_q <= req_multi ? CMD_RDN : CMD_RD1; state_q <= ST_CRDY; end
            OP_WRITE: begin cmd_q <= req_multi ? CMD_WRN : CMD_WR1; state_q <= ST_CRDY; end
            default:  ;
          endcase
        end
        ST_DUMMY: if (x_done) begin
          if (cnt_q == BW'(DUMMY_N - 1)) begin cnt_q <= '0; state_q <= ST_CRDY; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_CRDY: if (x_done && rx == BYTE_IDLE) begin cnt_q <= '0; state_q <= ST_CMD; end
        ST_CMD: if (x_done) begin
          if (cnt_q == BW'(5)) begin
            cnt_q   <= '0;
            poll_q  <= '0;
            state_q <= (cmd_q == CMD_STOP) ? ST_STUFF : ST_RESP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STUFF: if (x_done) state_q <= ST_RESP;
        ST_RESP: if (x_done) begin
          if (!rx[7]) begin
            case (cmd_q)
              CMD_RESET: if (rx == 8'h01) begin cmd_q <= CMD_INIT; state_q <= ST_CRDY; end
                         else begin err_q <= ERR_RESP; state_q <= ST_FIN; end
              CMD_INIT:  if (rx == 8'h00) begin fast_q <= 1'b1; state_q <= ST_FIN; end
                         else state_q <= ST_CRDY;
              CMD_STOP:  state_q <= ST_FIN;
              CMD_RD1, CMD_RDN:
                         if (rx == 8'h00) state_q <= ST_TOK;
                         else begin err_q <= ERR_RESP; state_q <= ST_FIN; end
              default:   if (rx == 8'h00) state_q <= ST_WRDY;
                         else begin err_q <= ERR_RESP; state_q <= ST_FIN; end
            endcase
          end else if (poll_q == PW'(POLL_N - 1)) begin
            if (err_q == ERR_NONE) begin err_q <= ERR_TIMEOUT; err_blk_q <= blk_q; end
            state_q <= ST_FIN;
          end else poll_q <= poll_q + 1'b1;
        end
        ST_TOK: if (x_done) begin
          if (rx == TOK_SINGLE) begin cnt_q <= '0; state_q <= ST_RDATA; end
          else if (rx != BYTE_IDLE) begin
            err_q     <= ERR_TOKEN;
            err_blk_q <= blk_q;
            if (multi_q) begin cmd_q <= CMD_STOP; arg_q <= '0; state_q <= ST_CRDY; end
            else state_q <= ST_FIN;
          end
        end
        ST_RDATA: if (x_done) begin
          rd_valid_q <= 1'b1;
          rd_data_q  <= rx;
          if (cnt_q == BW'(BLK_BYTES - 1)) begin cnt_q <= '0; state_q <= ST_RCRC; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_RCRC: if (x_done) begin
          if (cnt_q == BW'(1)) begin
            cnt_q <= '0;
            if (!last_blk) begin blk_q <= blk_q + 1'b1; state_q <= ST_TOK; end
            else if (multi_q) begin cmd_q <= CMD_STOP; arg_q <= '0; state_q <= ST_CRDY; end
            else state_q <= ST_FIN;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_WRDY: if (x_done && rx == BYTE_IDLE) state_q <= ST_WTOK;
        ST_WTOK: if (x_done) begin cnt_q <= '0; state_q <= ST_WDATA; end
        ST_WDATA: if (x_done) begin
          if (cnt_q == BW'(BLK_BYTES - 1)) begin cnt_q <= '0; state_q <= ST_WCRC; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_WCRC: if (x_done) begin
          if (cnt_q == BW'(1)) begin cnt_q <= '0; state_q <= ST_WRESP; end
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_WRESP: if (x_done) begin
          if (rx[4:0] == 5'h05) begin
            if (!last_blk) begin blk_q <= blk_q + 1'b1; state_q <= ST_WRDY; end
            else state_q <= multi_q ? ST_SRDY : ST_FIN;
          end else begin
            err_q <= ERR_REJECT; err_blk_q <= blk_q; state_q <= ST_FIN;
          end
        end
        ST_SRDY: if (x_done && rx == BYTE_IDLE) state_q <= ST_STOP;
        ST_STOP: if (x_done) state_q <= ST_FIN;
        ST_FIN:  if (x_done) state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CMD_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD && cnt_q == '0 && xfer_start_o) |-> xfer_tx_o[7:6] == 2'b01); // R1
  AST_POLL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESP) |-> (poll_q < PW'(POLL_N))); // R3
  AST_STUFF_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STUFF) |-> (cmd_q == CMD_STOP)); // R4
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R13
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o && cs_no)); // R10
  AST_FAST_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fast_clk_o) |-> $past(state_q == ST_RESP && cmd_q == CMD_INIT)); // R11
endmodule

// File: tb/test_sd_spi_seq.sv
module test_sd_spi_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BLK        = 512;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_ready_o;
  logic [1:0] req_op_i = '0;
  logic [31:0] req_addr_i = '0;
  logic [7:0] req_count_i = '0;
  logic       done_o, err_o, fast_clk_o;
  logic [2:0] err_code_o;
  logic [7:0] err_blk_o;
  logic       rd_valid_o, rd_ready_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       wr_valid_i = 1'b1, wr_ready_o;
  logic [7:0] wr_data_i = '0;
  logic       xfer_start_o, xfer_done_i = 1'b0, cs_no;
  logic [7:0] xfer_tx_o, xfer_rx_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_spi_seq #(.BLK_BYTES(BLK), .CNT_W(8)) i_sd_spi_seq (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i,
    .req_count_i, .done_o, .err_o, .err_code_o, .err_blk_o, .fast_clk_o,
    .rd_valid_o, .rd_ready_i, .rd_data_o, .wr_valid_i, .wr_ready_o, .wr_data_i,
    .xfer_start_o, .xfer_tx_o, .xfer_done_i, .xfer_rx_i, .cs_no
  );

  int errors = 0, checks = 0, cyc = 0, done_cnt = 0, wr_seq = 0, wexp = 0;
  logic [8:0]  exp_q[$];
  logic [7:0]  card_q[$];
  logic [7:0]  exp_rd[$];
  logic [10:0] exp_st[$];
  bit          armed = 0, wr_hs = 0;
  logic [7:0]  nxt = 8'hFF;

  function automatic logic [7:0] rpat(int b, int i);
    return 8'(b * 31 + i * 3 + 1);
  endfunction
  function automatic logic [7:0] wpat(int k);
    return 8'(k * 13 + 5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_x(input bit cs, input logic [7:0] t, input logic [7:0] r);
    exp_q.push_back({cs, t});
    card_q.push_back(r);
  endtask

  // R2: busy bytes then ready
  task automatic exp_ready(input int busy);
    repeat (busy) push_x(0, 8'hFF, 8'h00);
    push_x(0, 8'hFF, 8'hFF);
  endtask

  // R1 frame, R3 polling, R4 stuff byte
  task automatic exp_cmd(input logic [5:0] idx, input logic [31:0] arg, input int busy,
                         input int nff, input bit has_resp, input logic [7:0] resp);
    exp_ready(busy);
    push_x(0, {2'b01, idx}, 8'hFF);
    push_x(0, arg[31:24], 8'hFF);
    push_x(0, arg[23:16], 8'hFF);
    push_x(0, arg[15:8], 8'hFF);
    push_x(0, arg[7:0], 8'hFF);
    push_x(0, 8'h95, 8'hFF);
    if (idx == 6'd12) push_x(0, 8'hFF, 8'h3F);
    repeat (nff) push_x(0, 8'hFF, 8'hFF);
    if (has_resp) push_x(0, 8'hFF, resp);
  endtask

  // R5
  task automatic exp_rd_block(input int b, input int lead);
    repeat (lead) push_x(0, 8'hFF, 8'hFF);
    push_x(0, 8'hFF, 8'hFE);
    for (int i = 0; i < BLK; i++) begin
      push_x(0, 8'hFF, rpat(b, i));
      exp_rd.push_back(rpat(b, i));
    end
    push_x(0, 8'hFF, 8'hA5);
    push_x(0, 8'hFF, 8'h5A);
  endtask

  // R6, R7
  task automatic exp_wr_block(input logic [7:0] tok, input logic [7:0] resp, input int busy);
    exp_ready(busy);
    push_x(0, tok, 8'hFF);
    for (int i = 0; i < BLK; i++) begin
      push_x(0, wpat(wexp), 8'hFF);
      wexp++;
    end
    push_x(0, 8'hFF, 8'hFF);
    push_x(0, 8'hFF, 8'hFF);
    push_x(0, 8'hFF, resp);
  endtask

  task automatic exp_fin();  // R10
    push_x(1, 8'hFF, 8'hFF);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input int cnt,
                        input logic [2:0] code, input int eblk);
    int d0;
    exp_st.push_back({code, 8'(eblk)});
    wr_seq = 0;
    while (!req_ready_o) @(negedge clk);
    req_op_i = op; req_addr_i = addr; req_count_i = 8'(cnt); req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    d0 = done_cnt;
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R10 card bytes left", exp_q.size(), 0);
    check(exp_rd.size() == 0, "R5 read bytes left", exp_rd.size(), 0);
    exp_q.delete(); card_q.delete(); exp_rd.delete();
  endtask

  // scoreboard monitor and card model
  initial begin
    logic [8:0]  e;
    logic [10:0] s;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        errors++; checks++;
        $display("FAIL R14 watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
      if (rst_ni) begin
        if (wr_hs) wr_seq++;
        wr_data_i = wpat(wr_seq);
        wr_hs = wr_valid_i && wr_ready_o;
        xfer_done_i = 1'b0;
        if (armed) begin xfer_done_i = 1'b1; xfer_rx_i = nxt; armed = 0; end
        if (xfer_start_o) begin
          if (exp_q.size() == 0) check(0, "R10 unexpected byte", {cs_no, xfer_tx_o}, 0);
          else begin
            e = exp_q.pop_front();
            check({cs_no, xfer_tx_o} == e, "R1 R2 R6 R8 byte", {cs_no, xfer_tx_o}, e);
          end
          nxt = (card_q.size() != 0) ? card_q.pop_front() : 8'hFF;
          armed = 1;
        end
        rd_ready_i = (cyc % 3) != 0;
        if (rd_valid_o && rd_ready_i) begin
          if (exp_rd.size() == 0) check(0, "R13 extra read byte", rd_data_o, 0);
          else begin
            e = {1'b0, exp_rd.pop_front()};
            check(rd_data_o == e[7:0], "R5 read data", rd_data_o, e[7:0]);
          end
        end
        if (done_o) begin
          done_cnt++;
          if (exp_st.size() == 0) check(0, "R10 extra done", 1, 0);
          else begin
            s = exp_st.pop_front();
            check(err_code_o == s[10:8], "R12 error code", err_code_o, s[10:8]);
            check(err_blk_o == s[7:0], "R12 error block", err_blk_o, s[7:0]);
            check(err_o == (s[10:8] != 0), "R10 err flag", err_o, s[10:8] != 0);
          end
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14 reset state
    check(cs_no == 1'b1, "R14 cs after reset", cs_no, 1);
    check(req_ready_o == 1'b1, "R14 ready after reset", req_ready_o, 1);
    check(fast_clk_o == 1'b0, "R14 fast after reset", fast_clk_o, 0);
    check(done_o == 1'b0 && xfer_start_o == 1'b0, "R14 idle outputs", {done_o, xfer_start_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R8: bring-up with bad command 0 response, R11 stays slow
    repeat (10) push_x(1, 8'hFF, 8'hFF);
    exp_cmd(6'd0, 32'h0, 0, 1, 1, 8'h05);
    exp_fin();
    run_op(2'd0, 32'h0, 1, 3'd2, 0);
    check(fast_clk_o == 1'b0, "R11 fast after failed init", fast_clk_o, 0);

    // R8: good bring-up, command 1 repeated, R11 fast afterwards
    repeat (10) push_x(1, 8'hFF, 8'hFF);
    exp_cmd(6'd0, 32'h0, 1, 1, 1, 8'h01);
    exp_cmd(6'd1, 32'h0, 0, 0, 1, 8'h01);
    exp_cmd(6'd1, 32'h0, 2, 2, 1, 8'h00);
    exp_fin();
    run_op(2'd0, 32'h0, 1, 3'd0, 0);
    check(fast_clk_o == 1'b1, "R11 fast after init", fast_clk_o, 1);

    // R9 single read, R2 busy poll, R13 backpressure
    exp_cmd(6'd17, 32'h0001_2400, 2, 3, 1, 8'h00);
    exp_rd_block(0, 4);
    exp_fin();
    run_op(2'd1, 32'h0001_2400, 1, 3'd0, 0);

    // R9 multi read of 3 blocks, ended by command 12 with R4 stuff byte
    exp_cmd(6'd18, 32'h0000_0200, 0, 0, 1, 8'h00);
    for (int b = 0; b < 3; b++) exp_rd_block(b, b);
    exp_cmd(6'd12, 32'h0, 0, 1, 1, 8'h00);
    exp_fin();
    run_op(2'd1, 32'h0000_0200, 3, 3'd0, 0);

    // R3 response timeout
    exp_cmd(6'd17, 32'h0000_0600, 0, 10, 0, 8'h00);
    exp_fin();
    run_op(2'd1, 32'h0000_0600, 1, 3'd1, 0);

    // R12 bad token on block 1 of multi read still sends stop
    exp_cmd(6'd18, 32'h0000_0800, 0, 0, 1, 8'h00);
    exp_rd_block(0, 1);
    push_x(0, 8'hFF, 8'hFF);
    push_x(0, 8'hFF, 8'h0E);
    exp_cmd(6'd12, 32'h0, 1, 0, 1, 8'h00);
    exp_fin();
    run_op(2'd1, 32'h0000_0800, 3, 3'd3, 1);

    // R9 non-zero command response
    exp_cmd(6'd24, 32'h0000_0A00, 0, 0, 1, 8'h04);
    exp_fin();
    run_op(2'd2, 32'h0000_0A00, 1, 3'd2, 0);

    // R6 single write, R7 accepted with upper bits set
    wexp = 0;
    exp_cmd(6'd24, 32'h0000_0400, 0, 1, 1, 8'h00);
    exp_wr_block(8'hFE, 8'hE5, 2);
    exp_fin();
    run_op(2'd2, 32'h0000_0400, 1, 3'd0, 0);

    // R6 multi write of 2 blocks, R7 stop token after ready poll
    wexp = 0;
    exp_cmd(6'd25, 32'h0000_1000, 0, 0, 1, 8'h00);
    exp_wr_block(8'hFC, 8'h05, 0);
    exp_wr_block(8'hFC, 8'h25, 1);
    exp_ready(1);
    push_x(0, 8'hFD, 8'hFF);
    exp_fin();
    run_op(2'd2, 32'h0000_1000, 2, 3'd0, 0);

    // R7 rejected write on block 1 of multi write
    wexp = 0;
    exp_cmd(6'd25, 32'h0000_2000, 0, 0, 1, 8'h00);
    exp_wr_block(8'hFC, 8'h05, 0);
    exp_wr_block(8'hFC, 8'h0B, 0);
    exp_fin();
    run_op(2'd2, 32'h0000_2000, 2, 3'd4, 1);

    check(done_cnt == 10, "R10 completion count", done_cnt, 10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule